// File: doc/BRIEF.md
# Staircase Program-and-Verify Sequencer

This block runs the program-and-verify loop for a row of multi-level memory cells. A start strobe captures the target state of every cell, a table of verify thresholds (one per programmed state) and the pulse settings. The sequencer then sends a series of program pulses whose amplitude climbs. After every pulse comes a verify window, and at the end of that window each cell's sensed level, which arrives as a digital code, is compared with the threshold of that cell's target.

Each cell has its own inhibit bit. A cell is released from further pulses once it reaches its threshold, and cells that target the erased state are never pulsed. The loop ends with a one-cycle done when every cell is inhibited, or with a one-cycle fail when the loop budget runs out while some cell is still enabled. Analog pulse generation and sensing stay outside the block.

Top module: `ispp_ctrl`

## Requirements
- R1: A start seen while idle captures the target states, the threshold table, the step, the ceiling, both durations and the loop budget. The inhibit mask is loaded with one bit per erased-target cell (target code 0). Later changes on those inputs, and a start seen while busy, do not affect the running operation.
- R2: Each program pulse holds `pulse_on` high for max(`pulse_len`,1) cycles at a constant amplitude. It is followed by `verify_on` high for max(`verify_len`,1) cycles. The two strobes are never high together.
- R3: Pulse j (counted from 1) has amplitude min(`amp_ceil`, `amp_init` + (j−1)·`amp_step`). The value saturates at the ceiling and never wraps.
- R4: On the last verify cycle, every enabled cell i becomes inhibited if its sensed code (`sense_lvl[i*LVL_W +: LVL_W]`) is greater than or equal to the threshold of its target t (`vfy_lvls[(t−1)*LVL_W +: LVL_W]`). A code equal to the threshold counts as reached. Target t of cell i is `tgt_state[i*MBITS +: MBITS]`.
- R5: An inhibit bit, once set, stays set until the next accepted start, whatever the later sensed codes are.
- R6: When all cells are inhibited, `done` is high for exactly one cycle and the block returns to idle. With L loops run, `done` rises L·(max(`pulse_len`,1)+max(`verify_len`,1)+1)+1 cycles after the clock edge that accepted start. If every cell is erased-target, no pulse is issued and `done` comes one cycle after start.
- R7: If max(`max_loops`,1) loops have run and some cell is still enabled, `fail` is high for exactly one cycle after the last verify. No further pulse is issued and the block returns to idle.
- R8: After reset, and in the cycle after `done` or `fail`, all strobes and flags are low. Reset leaves every inhibit bit set and the amplitude at 0. `done` and `fail` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted only while idle) |
| tgt_state | input | NCELL*MBITS | Target state per cell, cell i at bits [i*MBITS +: MBITS] |
| vfy_lvls | input | (2^MBITS−1)*LVL_W | Threshold of state t at bits [(t−1)*LVL_W +: LVL_W] |
| sense_lvl | input | NCELL*LVL_W | Sensed code per cell |
| amp_init | input | AMP_W | Amplitude of the first pulse |
| amp_step | input | AMP_W | Amplitude increment per loop |
| amp_ceil | input | AMP_W | Amplitude ceiling |
| pulse_len | input | TIME_W | Pulse width in cycles (0 acts as 1) |
| verify_len | input | TIME_W | Verify window in cycles (0 acts as 1) |
| max_loops | input | LOOP_W | Loop budget (0 acts as 1) |
| pulse_amp | output | AMP_W | Current pulse amplitude |
| pulse_on | output | 1 | Program pulse active |
| inhibit | output | NCELL | Per-cell inhibit mask |
| verify_on | output | 1 | Verify window active |
| done | output | 1 | All cells reached target (one cycle) |
| fail | output | 1 | Loop budget exhausted (one cycle) |

## Verification
A wrong phase counter shows as a pulse or verify strobe of the wrong length, and it also shifts the `done` cycle, which the bench times to the exact cycle. A faulty comparator or mask register shows in the final `inhibit` value and in the loop count, since each cell's passing pulse is chosen by the bench. An amplitude error shows at the rising edge of the very pulse where it happens. A mask that is not sticky or not captured at start shows as soon as the sensed code of an already inhibited cell collapses, or when the target inputs are scrambled during the operation.

// File: rtl/ispp_pkg.sv
package ispp_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PULSE,
      ST_VERIFY,
      ST_CHECK,
      ST_DONE,
      ST_FAIL
   } ispp_state_e;
endpackage

// File: rtl/ispp_phase_timer.sv
module ispp_phase_timer #(
   parameter int TIME_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [TIME_W-1:0] load_val,
   input  logic              run,
   output logic              last
);
   logic [TIME_W-1:0] cnt;

   // a zero load behaves as a one-cycle phase
   assign last = (cnt <= TIME_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (load)        cnt <= load_val;
      else if (run && !last) cnt <= cnt - TIME_W'(1);
   end
endmodule

// File: rtl/ispp_amp_gen.sv
module ispp_amp_gen #(
   parameter int AMP_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init,
   input  logic             adv,
   input  logic [AMP_W-1:0] init_val,
   input  logic [AMP_W-1:0] step_val,
   input  logic [AMP_W-1:0] ceil_val,
   output logic [AMP_W-1:0] amp
);
   logic [AMP_W:0] sum;
   logic [AMP_W:0] ceil_x;

   assign sum    = {1'b0, amp} + {1'b0, step_val};
   assign ceil_x = {1'b0, ceil_val};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) amp <= '0;
      else if (init) amp <= (init_val > ceil_val) ? ceil_val : init_val;
      else if (adv)  amp <= (sum > ceil_x) ? ceil_val : sum[AMP_W-1:0];
   end
endmodule

// File: rtl/ispp_cell_verify.sv
module ispp_cell_verify #(
   parameter int NCELL = 8,
   parameter int MBITS = 2,
   parameter int LVL_W = 8,
   localparam int NLVL = (1 << MBITS) - 1
) (
   input  logic [NCELL*MBITS-1:0] tgt,
   input  logic [NLVL*LVL_W-1:0]  lvls,
   input  logic [NCELL*LVL_W-1:0] sense,
   output logic [NCELL-1:0]       pass
);
   for (genvar i = 0; i < NCELL; i++) begin : g_cell
      logic [MBITS-1:0] t;
      logic [LVL_W-1:0] thr;
      logic [LVL_W-1:0] s;
      assign t = tgt[i*MBITS +: MBITS];
      assign s = sense[i*LVL_W +: LVL_W];
      if (MBITS == 1) begin : g_single
         assign thr = lvls[LVL_W-1:0];
      end else begin : g_multi
         logic [MBITS-1:0] idx;
         assign idx = (t == '0) ? '0 : t - MBITS'(1);
         assign thr = lvls[idx*LVL_W +: LVL_W];
      end
      assign pass[i] = (t != '0) && (s >= thr);
   end
endmodule

// File: rtl/ispp_ctrl.sv
module ispp_ctrl
   import ispp_pkg::*;
#(
   parameter int NCELL  = 8,
   parameter int MBITS  = 2,
   parameter int LVL_W  = 8,
   parameter int AMP_W  = 8,
   parameter int TIME_W = 4,
   parameter int LOOP_W = 4
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               start,
   input  logic [NCELL*MBITS-1:0]             tgt_state,
   input  logic [((1<<MBITS)-1)*LVL_W-1:0]    vfy_lvls,
   input  logic [NCELL*LVL_W-1:0]             sense_lvl,
   input  logic [AMP_W-1:0]                   amp_init,
   input  logic [AMP_W-1:0]                   amp_step,
   input  logic [AMP_W-1:0]                   amp_ceil,
   input  logic [TIME_W-1:0]                  pulse_len,
   input  logic [TIME_W-1:0]                  verify_len,
   input  logic [LOOP_W-1:0]                  max_loops,
   output logic [AMP_W-1:0]                   pulse_amp,
   output logic                               pulse_on,
   output logic [NCELL-1:0]                   inhibit,
   output logic                               verify_on,
   output logic                               done,
   output logic                               fail
);
   localparam int NLVL   = (1 << MBITS) - 1;
   localparam int LVLS_W = NLVL * LVL_W;

   if (NCELL < 1) begin : g_bad_ncell
      $error("ispp_ctrl: NCELL must be at least 1");
   end
   if (MBITS < 1 || MBITS > 4) begin : g_bad_mbits
      $error("ispp_ctrl: MBITS must lie in 1..4");
   end
   if (AMP_W < 2 || TIME_W < 1 || LOOP_W < 1 || LVL_W < 2) begin : g_bad_w
      $error("ispp_ctrl: width parameter too small");
   end

   ispp_state_e st, st_nx;

   logic [NCELL*MBITS-1:0] tgt_q;
   logic [LVLS_W-1:0]      lvl_q;
   logic [AMP_W-1:0]       step_q, ceil_q;
   logic [TIME_W-1:0]      plen_q, vlen_q;
   logic [LOOP_W-1:0]      maxl_q, loop_cnt;
   logic [NCELL-1:0]       inh_q, erased_in, pass;

   logic accept, t_last, t_load, go_pulse, loop_end, all_inh, budget_out;
   logic [TIME_W-1:0] t_val;
   logic [LOOP_W-1:0] eff_max;

   for (genvar i = 0; i < NCELL; i++) begin : g_erased
      assign erased_in[i] = (tgt_state[i*MBITS +: MBITS] == '0);
   end

   assign accept     = (st == ST_IDLE) && start;
   assign all_inh    = &inh_q;
   assign eff_max    = (maxl_q == '0) ? LOOP_W'(1) : maxl_q;
   assign budget_out = (loop_cnt >= eff_max);
   assign loop_end   = (st == ST_VERIFY) && t_last;
   assign go_pulse   = (st == ST_CHECK) && !all_inh && !budget_out;

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_IDLE:   if (start) st_nx = (&erased_in) ? ST_DONE : ST_PULSE;
         ST_PULSE:  if (t_last) st_nx = ST_VERIFY;
         ST_VERIFY: if (t_last) st_nx = ST_CHECK;
         ST_CHECK:  st_nx = all_inh ? ST_DONE : (budget_out ? ST_FAIL : ST_PULSE);
         ST_DONE:   st_nx = ST_IDLE;
         ST_FAIL:   st_nx = ST_IDLE;
         default:   st_nx = ST_IDLE;
      endcase
   end

   always_comb begin
      t_load = accept || ((st == ST_PULSE) && t_last) || go_pulse;
      if (st == ST_IDLE)       t_val = pulse_len;
      else if (st == ST_PULSE) t_val = vlen_q;
      else                     t_val = plen_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         tgt_q    <= '0;
         lvl_q    <= '0;
         step_q   <= '0;
         ceil_q   <= '0;
         plen_q   <= '0;
         vlen_q   <= '0;
         maxl_q   <= '0;
         loop_cnt <= '0;
         inh_q    <= '1;
      end else begin
         st <= st_nx;
         if (accept) begin
            tgt_q    <= tgt_state;
            lvl_q    <= vfy_lvls;
            step_q   <= amp_step;
            ceil_q   <= amp_ceil;
            plen_q   <= pulse_len;
            vlen_q   <= verify_len;
            maxl_q   <= max_loops;
            loop_cnt <= '0;
            inh_q    <= erased_in;
         end else if (loop_end) begin
            loop_cnt <= loop_cnt + LOOP_W'(1);
            inh_q    <= inh_q | pass;
         end
      end
   end

   ispp_phase_timer #(.TIME_W(TIME_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .run      ((st == ST_PULSE) || (st == ST_VERIFY)),
      .last     (t_last)
   );

   ispp_amp_gen #(.AMP_W(AMP_W)) u_amp (
      .clk      (clk),
      .rst_n    (rst_n),
      .init     (accept),
      .adv      (go_pulse),
      .init_val (amp_init),
      .step_val (step_q),
      .ceil_val ((st == ST_IDLE) ? amp_ceil : ceil_q),
      .amp      (pulse_amp)
   );

   ispp_cell_verify #(.NCELL(NCELL), .MBITS(MBITS), .LVL_W(LVL_W)) u_cmp (
      .tgt   (tgt_q),
      .lvls  (lvl_q),
      .sense (sense_lvl),
      .pass  (pass)
   );

   assign pulse_on  = (st == ST_PULSE);
   assign verify_on = (st == ST_VERIFY);
   assign done      = (st == ST_DONE);
   assign fail      = (st == ST_FAIL);
   assign inhibit   = inh_q;
endmodule

// File: rtl/ispp_ctrl_chk.sv
module ispp_ctrl_chk #(
   parameter int NCELL = 8,
   parameter int AMP_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             pulse_on,
   input logic             verify_on,
   input logic             done,
   input logic             fail,
   input logic [NCELL-1:0] inhibit,
   input logic [AMP_W-1:0] pulse_amp,
   input logic [AMP_W-1:0] ceil_q
);
   p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(pulse_on && verify_on));

   p_amp_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse_on && $past(pulse_on)) |-> $stable(pulse_amp));

   p_amp_ceil_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_on |-> (pulse_amp <= ceil_q));

   p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> ((inhibit & $past(inhibit)) == $past(inhibit)));

   p_done_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (&inhibit));

   p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_fail_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fail |-> !(&inhibit));

   p_fail_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fail |=> (!fail && !pulse_on));

   p_end_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fail));
endmodule

bind ispp_ctrl ispp_ctrl_chk #(.NCELL(NCELL), .AMP_W(AMP_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .pulse_on  (pulse_on),
   .verify_on (verify_on),
   .done      (done),
   .fail      (fail),
   .inhibit   (inhibit),
   .pulse_amp (pulse_amp),
   .ceil_q    (ceil_q)
);

// File: tb/tb_ispp_ctrl.sv
module tb_ispp_ctrl;
   localparam int NCELL  = 8;
   localparam int MBITS  = 2;
   localparam int LVL_W  = 8;
   localparam int AMP_W  = 8;
   localparam int TIME_W = 4;
   localparam int LOOP_W = 4;
   localparam int NLVL   = (1 << MBITS) - 1;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic                      rst_n, start;
   logic [NCELL*MBITS-1:0]    tgt_state;
   logic [NLVL*LVL_W-1:0]     vfy_lvls;
   logic [NCELL*LVL_W-1:0]    sense_lvl;
   logic [AMP_W-1:0]          amp_init, amp_step, amp_ceil, pulse_amp;
   logic [TIME_W-1:0]         pulse_len, verify_len;
   logic [LOOP_W-1:0]         max_loops;
   logic                      pulse_on, verify_on, done, fail;
   logic [NCELL-1:0]          inhibit;

   ispp_ctrl #(.NCELL(NCELL), .MBITS(MBITS), .LVL_W(LVL_W), .AMP_W(AMP_W),
               .TIME_W(TIME_W), .LOOP_W(LOOP_W)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .tgt_state(tgt_state),
      .vfy_lvls(vfy_lvls), .sense_lvl(sense_lvl), .amp_init(amp_init),
      .amp_step(amp_step), .amp_ceil(amp_ceil), .pulse_len(pulse_len),
      .verify_len(verify_len), .max_loops(max_loops), .pulse_amp(pulse_amp),
      .pulse_on(pulse_on), .inhibit(inhibit), .verify_on(verify_on),
      .done(done), .fail(fail));

   int n_chk = 0;
   int n_err = 0;
   int tg[NCELL];
   int p_need[NCELL];
   int ofs[NCELL];
   bit drop[NCELL];
   int vl[NLVL];
   int c_init, c_step, c_ceil, c_plen, c_vlen, c_maxl;
   bit restart_en;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int imin(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

   function automatic int exp_amp(input int j);
      return imin(c_ceil, c_init + (j - 1) * c_step);
   endfunction

   function automatic int sense_of(input int i, input int k);
      int v;
      if (tg[i] == 0) return (i * 37 + k * 11) & 255;
      v = vl[tg[i] - 1];
      if (k >= p_need[i]) begin
         if (drop[i] && k > p_need[i]) return 0;
         return imin(255, v + ofs[i]);
      end
      return v - 1 - ofs[i];
   endfunction

   task automatic set_sense(input int k);
      for (int i = 0; i < NCELL; i++) sense_lvl[i*LVL_W +: LVL_W] = LVL_W'(sense_of(i, k));
   endtask

   task automatic drive_cfg();
      for (int i = 0; i < NCELL; i++) tgt_state[i*MBITS +: MBITS] = MBITS'(tg[i]);
      for (int t = 0; t < NLVL; t++) vfy_lvls[t*LVL_W +: LVL_W] = LVL_W'(vl[t]);
      amp_init = AMP_W'(c_init); amp_step = AMP_W'(c_step); amp_ceil = AMP_W'(c_ceil);
      pulse_len = TIME_W'(c_plen); verify_len = TIME_W'(c_vlen); max_loops = LOOP_W'(c_maxl);
   endtask

   task automatic scramble();
      tgt_state = NCELL*MBITS'($urandom);
      vfy_lvls  = NLVL*LVL_W'($urandom);
      amp_init  = AMP_W'($urandom); amp_step = AMP_W'($urandom); amp_ceil = AMP_W'($urandom);
      pulse_len = TIME_W'($urandom); verify_len = TIME_W'($urandom); max_loops = LOOP_W'($urandom);
   endtask

   task automatic rand_cfg();
      for (int i = 0; i < NCELL; i++) begin
         tg[i] = $urandom % 4; p_need[i] = 1 + $urandom % 6;
         ofs[i] = $urandom % 3; drop[i] = $urandom % 2;
      end
      for (int t = 0; t < NLVL; t++) vl[t] = 4 + $urandom % 247;
      c_init = $urandom % 64; c_step = $urandom % 32; c_ceil = 100 + $urandom % 156;
      c_plen = $urandom % 4; c_vlen = $urandom % 4; c_maxl = $urandom % 8;
   endtask

   task automatic run_op(input string name);
      int L = 0;
      int effmax, loops, pe, ve, lat, cyc, npul, prun, vrun;
      bit exp_done, prev_p, prev_v, hung;
      logic [NCELL-1:0] er_mask, fin_mask;
      for (int i = 0; i < NCELL; i++) if (tg[i] != 0 && p_need[i] > L) L = p_need[i];
      effmax   = (c_maxl == 0) ? 1 : c_maxl;
      exp_done = (L <= effmax);
      loops    = exp_done ? L : effmax;
      pe = (c_plen == 0) ? 1 : c_plen;
      ve = (c_vlen == 0) ? 1 : c_vlen;
      lat = loops * (pe + ve + 1) + 1;
      for (int i = 0; i < NCELL; i++) begin
         er_mask[i]  = (tg[i] == 0);
         fin_mask[i] = (tg[i] == 0) || (p_need[i] <= loops);
      end
      @(negedge clk);
      drive_cfg(); set_sense(0); start = 1'b1;
      @(negedge clk);
      start = 1'b0; scramble();
      cyc = 1; npul = 0; prun = 0; vrun = 0; prev_p = 0; prev_v = 0; hung = 0;
      while (1) begin
         if (cyc == 1) chk(inhibit == er_mask, "R1", {name, " mask at start"}, inhibit, er_mask);
         start = (restart_en && cyc == 2);
         if (pulse_on && !prev_p) begin
            npul++;
            chk(int'(pulse_amp) == exp_amp(npul), "R3", {name, " pulse amplitude"},
                pulse_amp, exp_amp(npul));
            set_sense(npul);
         end
         if (pulse_on) prun++;
         else if (prev_p) begin
            chk(prun == pe, "R2", {name, " pulse width"}, prun, pe); prun = 0;
         end
         if (verify_on) vrun++;
         else if (prev_v) begin
            chk(vrun == ve, "R2", {name, " verify width"}, vrun, ve); vrun = 0;
         end
         if (done || fail) break;
         if (cyc > 4000) begin hung = 1; break; end
         prev_p = pulse_on; prev_v = verify_on;
         scramble();
         @(negedge clk);
         cyc++;
      end
      start = 1'b0;
      if (hung) chk(1'b0, "R6", {name, " watchdog"}, cyc, lat);
      chk(done == exp_done, exp_done ? "R6" : "R7", {name, " done vs fail"}, done, exp_done);
      chk(cyc == lat, exp_done ? "R6" : "R7", {name, " end latency"}, cyc, lat);
      chk(npul == loops, "R7", {name, " pulse count"}, npul, loops);
      chk(inhibit == fin_mask, "R4", {name, " final mask R5"}, inhibit, fin_mask);
      @(negedge clk);
      chk(!done && !fail && !pulse_on && !verify_on, "R8", {name, " quiet after end"},
          {done, fail, pulse_on, verify_on}, 0);
      sense_lvl = '0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      int seed;
      seed = $urandom(32'h5A17);
      rst_n = 1'b0; start = 1'b0; sense_lvl = '0; restart_en = 0;
      rand_cfg(); drive_cfg();
      repeat (3) @(negedge clk);
      chk(!pulse_on && !verify_on && !done && !fail, "R8", "reset strobes",
          {pulse_on, verify_on, done, fail}, 0);
      chk(inhibit == '1 && pulse_amp == '0, "R8", "reset mask and amplitude",
          {inhibit, pulse_amp}, {8'hFF, 8'h00});
      rst_n = 1'b1;
      @(negedge clk);

      // R6: every cell erased-target, no pulse at all
      rand_cfg();
      for (int i = 0; i < NCELL; i++) tg[i] = 0;
      run_op("all-erased");

      // R3: ceiling reached after a few large steps
      rand_cfg();
      c_init = 200; c_step = 40; c_ceil = 230; c_maxl = 8;
      for (int i = 0; i < NCELL; i++) begin tg[i] = 1 + i % 3; p_need[i] = 1 + i % 5; end
      run_op("ceiling");

      // R3: initial value above ceiling is clamped
      rand_cfg();
      c_init = 250; c_ceil = 120; c_maxl = 7; c_step = 3;
      run_op("init-clamp");

      // R7: budget exhausted
      rand_cfg();
      c_maxl = 2; tg[0] = 3; p_need[0] = 6;
      run_op("budget");

      // R7: zero budget acts as one loop
      rand_cfg();
      c_maxl = 0;
      for (int i = 0; i < NCELL; i++) p_need[i] = 1;
      run_op("zero-budget-pass");
      rand_cfg();
      c_maxl = 0; tg[3] = 2; p_need[3] = 2;
      run_op("zero-budget-fail");

      // R4: sensed code exactly at threshold, shortest phases
      rand_cfg();
      c_plen = 0; c_vlen = 0; c_maxl = 8;
      for (int i = 0; i < NCELL; i++) begin ofs[i] = 0; tg[i] = 1 + i % 3; end
      run_op("equal-threshold");

      // R5: passed cells collapse afterwards, R1: start while busy
      rand_cfg();
      c_maxl = 8; restart_en = 1;
      for (int i = 0; i < NCELL; i++) begin drop[i] = 1; tg[i] = 1 + i % 3; end
      run_op("collapse-restart");
      restart_en = 0;

      for (int n = 0; n < 40; n++) begin
         rand_cfg();
         restart_en = n[0];
         run_op("random");
      end
      restart_en = 0;

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule